// File: doc/BRIEF.md
# Marker-bit asynchronous serial receiver

This block turns an asynchronous serial line into bytes. Each frame has one low start bit, eight data bits sent least-significant first, and one high stop bit. There is no parity. The block runs from one system clock. That clock does not have to be an integer multiple of the baud rate: the half-bit and full-bit periods are parameters, each rounded to the nearest whole number of clocks. The input passes through a two-flop synchroniser. A falling level must then stay low for half a bit period before reception is committed, so short low glitches are rejected.

A three-state controller (idle, start check, shifting) drives a down-counting baud timer. The block has no bit counter. When the start bit is confirmed, the shift register is loaded with a zero at its input end and ones everywhere else. Each later mid-bit sample pushes that zero one place toward the far end. Once the zero reaches the far end, all eight data bits are in, and the next sample is the stop bit. A good stop bit updates the output byte and raises a one-clock valid strobe. A bad stop bit raises a one-clock framing-error strobe and leaves the byte as it was.

Top module: `uart_rx_marker`

## Requirements
- R1: After reset, `rx_byte` is 0 and both `rx_valid` and `rx_frame_err` are low.
- R2: For a frame with a high stop bit, `rx_byte` shows the eight data bits, with the first data bit on the line at bit 0. `rx_byte` is updated in the same cycle that `rx_valid` is high.
- R3: `rx_valid` is high for exactly one clock for each accepted frame.
- R4: A low level on the synchronised input that does not reach the half-bit count causes no strobe and leaves `rx_byte` unchanged. This covers lengths from 1 clock up to and including HALF clocks. The block then receives the next frame correctly.
- R5: When the stop-bit sample reads 0, `rx_frame_err` is high for exactly one clock, `rx_valid` stays low and `rx_byte` keeps its previous value.
- R6: The half-bit count is HALF = round(CLK_HZ / (2·BAUD)) and the full-bit count is FULL = round(CLK_HZ / BAUD). Frames are received correctly when CLK_HZ / BAUD is not an integer.
- R7: Frames sent back to back, where a start bit directly follows the previous stop bit, are all received.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rxd_in | input | 1 | Serial data line; high when idle |
| rx_byte | output | DATA_W | Last byte that was accepted |
| rx_valid | output | 1 | One-clock strobe when a byte is accepted |
| rx_frame_err | output | 1 | One-clock strobe when the stop bit reads 0 |

## Verification
The bench sends all 256 byte values back to back, with no idle time between frames. It uses a clock-to-baud ratio of about 13.9, so any rounding error in the half-bit or full-bit count builds up over a frame. An error would show up as a byte with bits shifted by one place, or as a false framing error at the stop bit. Low pulses from one clock up to exactly the half-bit count are swept. A start check that did not stay armed for the whole half bit would turn these pulses into spurious 0xFF bytes. A frame with a zero stop bit must give a framing-error strobe and must not overwrite the held byte. A design that stored the byte before checking the stop bit would fail this test.

// File: rtl/rx_pkg.sv
package rx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_START = 2'd1,
        ST_SHIFT = 2'd2
    } rx_state_e;

    // Nearest-integer division for clock-to-baud ratios.
    function automatic int div_round(input int num, input int den);
        return (num + den / 2) / den;
    endfunction

endpackage

// File: rtl/rx_sync.sv
module rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] stg_d, stg_q;

    generate
        if (STAGES == 1) begin : g_one
            always_comb stg_d = din;
        end else begin : g_many
            always_comb stg_d = {stg_q[STAGES-2:0], din};
        end
    endgenerate

    // Idle line is high, so the flops come out of reset at 1.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q <= '1;
        else        stg_q <= stg_d;
    end

    assign dout = stg_q[STAGES-1];
endmodule

// File: rtl/rx_baud_timer.sv
module rx_baud_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired,
    output logic [CNT_W-1:0] cnt
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)            cnt_d = load_val;
        else if (cnt_q != 0) cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == '0);
    assign cnt     = cnt_q;
endmodule

// File: rtl/rx_marker_shift.sv
module rx_marker_shift #(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         arm,
    input  logic         shift_en,
    input  logic         din,
    output logic [W-2:0] data,
    output logic         done
);
    logic [W-1:0] sr_d, sr_q;

    always_comb begin
        sr_d = sr_q;
        // Start bit (0) at the input end, ones elsewhere.
        if (arm)           sr_d = {1'b0, {(W-1){1'b1}}};
        else if (shift_en) sr_d = {din, sr_q[W-1:1]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr_q <= '1;
        else        sr_q <= sr_d;
    end

    assign done = ~sr_q[0];
    assign data = sr_q[W-1:1];
endmodule

// File: rtl/uart_rx_marker.sv
module uart_rx_marker
    import rx_pkg::*;
#(
    parameter int CLK_HZ      = 50_000_000,
    parameter int BAUD        = 115_200,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rxd_in,
    output logic [DATA_W-1:0] rx_byte,
    output logic              rx_valid,
    output logic              rx_frame_err
);
    localparam int FULL_CNT = div_round(CLK_HZ, BAUD);
    localparam int HALF_CNT = div_round(CLK_HZ, 2 * BAUD);
    localparam int CNT_W    = $clog2(FULL_CNT);
    localparam int SR_W     = DATA_W + 1;

    typedef struct packed {
        rx_state_e         state;
        logic [DATA_W-1:0] byte_out;
        logic              valid;
        logic              ferr;
    } ctrl_t;

    ctrl_t ctrl_d, ctrl_q;

    logic              rxs;
    logic              tmr_load;
    logic [CNT_W-1:0]  tmr_val;
    logic              tmr_exp;
    logic [CNT_W-1:0]  tmr_cnt;
    logic              sr_arm;
    logic              sr_shift;
    logic [DATA_W-1:0] sr_data;
    logic              sr_done;

    rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (rxd_in),
        .dout (rxs)
    );

    rx_baud_timer #(.CNT_W(CNT_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (tmr_load),
        .load_val(tmr_val),
        .expired (tmr_exp),
        .cnt     (tmr_cnt)
    );

    rx_marker_shift #(.W(SR_W)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .arm     (sr_arm),
        .shift_en(sr_shift),
        .din     (rxs),
        .data    (sr_data),
        .done    (sr_done)
    );

    always_comb begin
        ctrl_d       = ctrl_q;
        ctrl_d.valid = 1'b0;
        ctrl_d.ferr  = 1'b0;
        tmr_load     = 1'b0;
        tmr_val      = CNT_W'(FULL_CNT - 1);
        sr_arm       = 1'b0;
        sr_shift     = 1'b0;
        unique case (ctrl_q.state)
            ST_IDLE: begin
                if (!rxs) begin
                    tmr_load     = 1'b1;
                    tmr_val      = CNT_W'(HALF_CNT - 1);
                    ctrl_d.state = ST_START;
                end
            end
            ST_START: begin
                if (rxs) begin
                    ctrl_d.state = ST_IDLE;
                end else if (tmr_exp) begin
                    tmr_load     = 1'b1;
                    sr_arm       = 1'b1;
                    ctrl_d.state = ST_SHIFT;
                end
            end
            ST_SHIFT: begin
                if (tmr_exp) begin
                    if (sr_done) begin
                        if (rxs) begin
                            ctrl_d.byte_out = sr_data;
                            ctrl_d.valid    = 1'b1;
                        end else begin
                            ctrl_d.ferr     = 1'b1;
                        end
                        ctrl_d.state = ST_IDLE;
                    end else begin
                        sr_shift = 1'b1;
                        tmr_load = 1'b1;
                    end
                end
            end
            default: ctrl_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q.state    <= ST_IDLE;
            ctrl_q.byte_out <= '0;
            ctrl_q.valid    <= 1'b0;
            ctrl_q.ferr     <= 1'b0;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign rx_byte      = ctrl_q.byte_out;
    assign rx_valid     = ctrl_q.valid;
    assign rx_frame_err = ctrl_q.ferr;
endmodule

// File: rtl/rx_checker.sv
module rx_checker
    import rx_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int CNT_W    = 4,
    parameter int FULL_CNT = 14
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rxs,
    input rx_state_e         state,
    input logic [CNT_W-1:0]  cnt,
    input logic [DATA_W-1:0] rx_byte,
    input logic              rx_valid,
    input logic              rx_frame_err
);
    AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid); // R3

    AST_FERR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_frame_err |=> !rx_frame_err); // R5

    AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(rx_valid && rx_frame_err)); // R5

    AST_BYTE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_valid |-> $stable(rx_byte)); // R4

    AST_VALID_AFTER_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> $past(state) == ST_SHIFT); // R2

    AST_START_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_START && rxs) |=> state == ST_IDLE); // R4

    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        32'(cnt) <= FULL_CNT - 1); // R6
endmodule

bind uart_rx_marker rx_checker #(
    .DATA_W  (DATA_W),
    .CNT_W   (CNT_W),
    .FULL_CNT(FULL_CNT)
) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rxs         (rxs),
    .state       (ctrl_q.state),
    .cnt         (tmr_cnt),
    .rx_byte     (rx_byte),
    .rx_valid    (rx_valid),
    .rx_frame_err(rx_frame_err)
);

// File: tb/test_uart_rx_marker.sv
`timescale 1ns/1ps
module test_uart_rx_marker;
    localparam int CLK_HZ = 1_000_000;
    localparam int BAUD   = 72_000;
    localparam int HALF   = (CLK_HZ + BAUD) / (2 * BAUD);
    localparam int FULL   = (CLK_HZ + BAUD / 2) / BAUD;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rxd_in = 1'b1;
    logic [7:0] rx_byte;
    logic       rx_valid;
    logic       rx_frame_err;

    int n_cmp = 0;
    int n_bad = 0;
    int vcnt = 0;
    int fcnt = 0;
    logic [7:0] last_byte = 8'h00;
    bit finished = 0;

    always #2.5 clk = ~clk;

    uart_rx_marker #(.CLK_HZ(CLK_HZ), .BAUD(BAUD)) i_uart_rx_marker (
        .clk         (clk),
        .rst_n       (rst_n),
        .rxd_in      (rxd_in),
        .rx_byte     (rx_byte),
        .rx_valid    (rx_valid),
        .rx_frame_err(rx_frame_err)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            if (rx_valid) begin
                vcnt++;
                last_byte = rx_byte;
            end
            if (rx_frame_err) fcnt++;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int edge_at(input int k);
        return (k * CLK_HZ + BAUD / 2) / BAUD;
    endfunction

    // Drives one frame with bit edges at rounded fractional positions.
    task automatic send_frame(input logic [7:0] d, input logic stop);
        for (int k = 0; k < 10; k++) begin
            if (k == 0)      rxd_in = 1'b0;
            else if (k == 9) rxd_in = stop;
            else             rxd_in = d[k-1];
            repeat (edge_at(k + 1) - edge_at(k)) @(negedge clk);
        end
        rxd_in = 1'b1;
    endtask

    initial begin
        int v0, f0;
        logic [7:0] held;
        repeat (4) @(negedge clk);
        check("R1 byte", int'(rx_byte), 0);
        check("R1 valid", int'(rx_valid), 0);
        check("R1 ferr", int'(rx_frame_err), 0);
        rst_n = 1'b1;
        repeat (3 * FULL) @(negedge clk);
        check("R1 idle no strobe", vcnt + fcnt, 0);

        // R6: ratio is deliberately non-integer; derived counts from rounding.
        check("R6 non-integer ratio", int'((CLK_HZ % BAUD) != 0), 1);
        check("R6 FULL", FULL, 14);
        check("R6 HALF", HALF, 7);

        // R2 R3 R7: all 256 values, back to back.
        for (int b = 0; b < 256; b++) begin
            v0 = vcnt;
            f0 = fcnt;
            send_frame(8'(b), 1'b1);
            check("R3 R7 one valid per frame", vcnt - v0, 1);
            check("R5 no ferr on good frame", fcnt - f0, 0);
            check("R2 byte value", int'(last_byte), b);
        end
        repeat (2 * FULL) @(negedge clk);

        // R4: low pulses up to HALF clocks are ignored.
        send_frame(8'hA5, 1'b1);
        repeat (FULL) @(negedge clk);
        held = rx_byte;
        for (int len = 1; len <= HALF; len++) begin
            v0 = vcnt;
            f0 = fcnt;
            rxd_in = 1'b0;
            repeat (len) @(negedge clk);
            rxd_in = 1'b1;
            repeat (12 * FULL) @(negedge clk);
            check("R4 glitch no valid", vcnt - v0, 0);
            check("R4 glitch no ferr", fcnt - f0, 0);
            check("R4 byte unchanged", int'(rx_byte), int'(held));
        end
        v0 = vcnt;
        send_frame(8'h3C, 1'b1);
        check("R4 recovery valid", vcnt - v0, 1);
        check("R4 recovery byte", int'(last_byte), 8'h3C);

        // R5: bad stop bits.
        for (int i = 0; i < 4; i++) begin
            logic [7:0] pat;
            pat = 8'(8'h81 + 8'(i * 37));
            repeat (FULL) @(negedge clk);
            held = rx_byte;
            v0 = vcnt;
            f0 = fcnt;
            send_frame(pat, 1'b0);
            repeat (2 * FULL) @(negedge clk);
            check("R5 one ferr", fcnt - f0, 1);
            check("R5 no valid", vcnt - v0, 0);
            check("R5 byte held", int'(rx_byte), int'(held));
        end
        v0 = vcnt;
        send_frame(8'h5A, 1'b1);
        check("R5 good frame after error", int'(last_byte), 8'h5A);
        check("R3 single valid after error", vcnt - v0, 1);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200_000) @(posedge clk);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule